// File: doc/BRIEF.md
# Circular Hardware Return Stack

This block keeps return addresses for a small processor core. When a subroutine call runs, or an interrupt forces a branch, the sequencer asserts a push request together with the 13-bit address to come back to. When any return runs (a plain return, a return that loads a literal, or a return from interrupt), the sequencer takes the address shown on the pop output and asserts a pop request. The pop output always shows the most recently pushed entry that has not yet been popped. The sequencer can therefore use it as the next program counter in the same cycle.

The storage has eight entries and is separate from program and data memory. The pointer is internal and cannot be read or written from outside. The storage is a ring with no end. A ninth push overwrites the first entry, and a pop on an empty stack returns whatever entry the wrapped pointer selects. No flag reports either case. Reset clears only the pointer and leaves the entry contents as they were.

Top module: `ret_stack`

## Requirements
- R1: One cycle after a push request, `pop_addr` equals the `push_addr` value presented with that request.
- R2: Entries come back in last-in, first-out order. After a pop, `pop_addr` shows the entry pushed before the one just removed.
- R3: The stack holds eight entries of 13 bits. The ninth push since reset replaces the entry written by the first push, and the tenth replaces the second.
- R4: Popping more entries than were pushed keeps walking backwards around the ring. Each further pop shows the entry stored in the next lower slot, modulo 8, and no error indication exists.
- R5: When push and pop are requested in the same cycle, the pop is ignored. The pushed value appears on `pop_addr` and the pointer advances exactly as for a lone push.
- R6: Reset sets the pointer to slot 0 and keeps the entry contents. Right after reset, `pop_addr` shows the contents of slot 7.
- R7: In a cycle with neither request, the stored entries and the pointer are unchanged, so `pop_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the pointer |
| push_req | input | 1 | Store `push_addr` and advance the pointer |
| push_addr | input | 13 | Return address to store |
| pop_req | input | 1 | Retreat the pointer, removing the entry shown on `pop_addr` |
| pop_addr | output | 13 | Entry selected by the pointer minus one, modulo 8 |

## Verification
The assertions check these properties on every cycle:
- the pointer advances by one on a push, including when a pop is requested at the same time;
- the pointer retreats by one on a lone pop;
- the pointer returns to zero after reset;
- the written slot holds the pushed data;
- `pop_addr` is stable when neither request is active.

Only the bench's scenarios can show the behaviour that depends on history:
- the order of values over long push and pop runs;
- the overwrite of the oldest entries after ten pushes;
- popping past empty, which walks around the ring;
- the survival of entry contents across a reset.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    localparam int unsigned RS_DEPTH  = 8;
    localparam int unsigned RS_ADDR_W = 13;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } rs_op_e;

    // A push outranks a pop requested in the same cycle.
    function automatic rs_op_e rs_decode(input logic push, input logic pop);
        if (push)     return OP_PUSH;
        else if (pop) return OP_POP;
        else          return OP_IDLE;
    endfunction

endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
    import ret_stack_pkg::*;
#(
    parameter int unsigned DEPTH = RS_DEPTH,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  rs_op_e        op,
    output logic [PW-1:0] wr_slot,
    output logic [PW-1:0] top_slot
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    function automatic logic [PW-1:0] step_up(input logic [PW-1:0] v);
        return (v == LAST) ? '0 : v + PW'(1);
    endfunction

    function automatic logic [PW-1:0] step_down(input logic [PW-1:0] v);
        return (v == '0) ? LAST : v - PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_PUSH: st_d.ptr = step_up(st_q.ptr);
            OP_POP:  st_d.ptr = step_down(st_q.ptr);
            default: st_d.ptr = st_q.ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_slot  = st_q.ptr;
    assign top_slot = step_down(st_q.ptr);

    // R5: a push (also when a pop is requested with it) advances by one
    p_push_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (wr_slot == step_up($past(wr_slot))));

    // R2: a lone pop retreats by one
    p_pop_retreat_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP) |=> (wr_slot == step_down($past(wr_slot))));

    // R6: reset returns the pointer to slot 0
    p_reset_zero_r6: assert property (@(posedge clk)
        rst |=> (wr_slot == '0));

endmodule

// File: rtl/ret_stack_store.sv
module ret_stack_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 13,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_slot,
    input  logic [AW-1:0] wr_data,
    input  logic [PW-1:0] rd_slot,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] ent_q [DEPTH];
    logic [AW-1:0] ent_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == PW'(g));

        always_comb begin
            ent_d[g] = hit ? wr_data : ent_q[g];
        end

        // Contents are deliberately not reset.
        always_ff @(posedge clk) begin
            ent_q[g] <= ent_d[g];
        end
    end

    assign rd_data = ent_q[rd_slot];

    // R3: the addressed slot holds the pushed data after the write
    p_write_lands_r3: assert property (@(posedge clk)
        wr_en |=> (ent_q[$past(wr_slot)] == $past(wr_data)));

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int unsigned DEPTH = RS_DEPTH,
    parameter int unsigned AW    = RS_ADDR_W,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_req,
    output logic [AW-1:0] pop_addr
);

    rs_op_e        op;
    logic [PW-1:0] wr_slot;
    logic [PW-1:0] top_slot;

    assign op = rs_decode(push_req, pop_req);

    ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_slot  (wr_slot),
        .top_slot (top_slot)
    );

    ret_stack_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (op == OP_PUSH),
        .wr_slot (wr_slot),
        .wr_data (push_addr),
        .rd_slot (top_slot),
        .rd_data (pop_addr)
    );

    // R1: the pushed address is on top one cycle later
    p_push_on_top_r1: assert property (@(posedge clk) disable iff (rst)
        push_req |=> (pop_addr == $past(push_addr)));

    // R7: without requests the top is unchanged
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!push_req && !pop_req) |=> $stable(pop_addr));

endmodule

// File: tb/tb_ret_stack.sv
module tb_ret_stack;

    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_req = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic          pop_req = 1'b0;
    logic [AW-1:0] pop_addr;

    int checks = 0;
    int errors = 0;

    // Reference ring kept with plain arithmetic.
    logic [AW-1:0] mdl [8];
    int            mptr = 0;

    always #2 clk = ~clk;

    ret_stack dut (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .push_addr (push_addr),
        .pop_req   (pop_req),
        .pop_addr  (pop_addr)
    );

    function automatic logic [AW-1:0] val(input int i);
        return AW'(13'h0A5 + i * 13'h123);
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] exp);
        checks++;
        if (pop_addr !== exp) begin
            errors++;
            $display("FAIL %s: pop_addr=%h expected=%h", req, pop_addr, exp);
        end
    endtask

    function automatic logic [AW-1:0] mtop();
        return mdl[(mptr + 7) % 8];
    endfunction

    // Drive at negedge, let one rising edge pass, return at negedge.
    task automatic cyc(input logic pu, input logic po, input logic [AW-1:0] d);
        push_req = pu; pop_req = po; push_addr = d;
        @(posedge clk);
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        if (pu) begin
            mdl[mptr] = d;
            mptr = (mptr + 1) % 8;
        end else if (po) begin
            mptr = (mptr + 7) % 8;
        end
    endtask

    initial begin
        repeat (500) @(posedge clk);
        errors++;
        $display("FAIL watchdog: pop_addr=%h expected=completion", pop_addr);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;

        // R2: short LIFO run
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, val(20 + i));
            chk("R1", val(20 + i));
        end
        for (int i = 2; i > 0; i--) begin
            cyc(1'b0, 1'b1, '0);
            chk("R2", val(20 + i - 1));
        end
        cyc(1'b0, 1'b1, '0);

        // R3: ten pushes from slot 0 overwrite the two oldest entries
        rst = 1'b1; cyc(1'b0, 1'b0, '0); rst = 1'b0; mptr = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1'b1, 1'b0, val(i));
            chk("R1", val(i));
        end
        // Slots hold v8,v9,v2..v7. Popping walks back around the ring.
        for (int k = 0; k < 10; k++) begin
            int s;
            s = (1 - k + 80) % 8;
            chk((k < 8) ? "R3" : "R4", (s < 2) ? val(s + 8) : val(s));
            cyc(1'b0, 1'b1, '0);
        end
        chk("R4", mtop());

        // R5: push and pop together behave as a push
        cyc(1'b1, 1'b1, 13'h1ABC);
        chk("R5", 13'h1ABC);
        cyc(1'b0, 1'b1, '0);
        chk("R5", mtop());

        // R7: idle cycles leave the top unchanged
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b0, 13'h0F0F);
            chk("R7", mtop());
        end

        // R6: reset clears the pointer and keeps the contents
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, val(40 + i));
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, val(60 + i));
        rst = 1'b1; cyc(1'b0, 1'b0, '0); rst = 1'b0; mptr = 0;
        chk("R6", mdl[7]);
        cyc(1'b1, 1'b0, 13'h0777);
        chk("R6", 13'h0777);
        cyc(1'b0, 1'b1, '0);
        chk("R6", mdl[7]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule